// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block sequences a processor's standby power-down. Software writes a request bit in a small control register; the sequencer then passes through a short clock-stopping phase, gates the internal core clock, and reports each phase on a two-pin status code. While the standby code is shown, the external input clock may be halted or retuned. The wake-up logic does not act until the clock is reported as running again.

An enabled interrupt request ends standby. The internal timer's own request is excluded from waking. The watchdog up-counter, preloaded on entry, is then reused as a settling timer. The core clock stays gated until the counter overflows past all-ones, which allows for oscillator start-up and PLL lock. The block then re-enables the clock, returns the status pins to the run code and pulses a resume strobe for interrupt exception handling.

After such a wake the request bit stays set and the counter keeps running. Software clears the bit to freeze it. A manual reset cancels standby at once and skips the settling wait. A manual reset also wins over an interrupt that arrives in the same cycle.

Top module: `standby_seq`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge), `core_clk_en`=1, `ckout_en`=1, {`stat1`,`stat0`}=00, `wdt_count`=0 and `resume`=0.
- R2: In run mode, a write with `wr_addr`=0 and `wr_data[0]`=1 starts standby. After that edge `core_clk_en`=0, {`stat1`,`stat0`}=10 and `wdt_count` holds the preload (the last value written at `wr_addr`=1). After the following edge {`stat1`,`stat0`}=01.
- R3: While in standby (code 01), the block stays in standby and `wdt_count` holds in three cases: no request is present; the only request is on the timer line (`irq_req[3]`, cleared from `WAKE_MASK`); or `clk_ok`=0.
- R4: An enabled request with `clk_ok`=1 moves the block into settling. In settling the clock stays gated, the code stays 01, and `wdt_count` advances by one per prescaled tick.
- R5: A prescaled tick while `wdt_count` is all-ones wraps the count to 0. After that edge `core_clk_en`=1, the code is 00 and `resume` is 1 for exactly one cycle. The wake therefore takes 256 minus the preload prescaled ticks.
- R6: The prescale field `wr_data[2:1]` of the control write, value k, makes the counter advance once every 2^k `tick` pulses. The prescaler phase restarts in standby.
- R7: A manual reset (`man_rst_n` low at an edge) during entry, standby or settling returns the block to run mode with code 00 and `resume`=0. It does so even if an interrupt is present in the same cycle. `ckout_en` is 1 whenever either reset is low and 0 while the clock is gated outside reset.
- R8: Register writes while the clock is gated are ignored. This covers both clearing the request bit and writing a new preload.
- R9: After an interrupt wake the request bit stays set and `wdt_count` keeps counting prescaled ticks. A control write with `wr_data[0]`=0 halts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| man_rst_n | input | 1 | Manual reset, synchronous, active low; cancels standby |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control (bit 0 request, bits 2:1 prescale), 1 = counter preload |
| wr_data | input | CNT_W | Write data |
| irq_req | input | NUM_IRQ | Interrupt request lines; bit 3 is the internal timer |
| clk_ok | input | 1 | External input clock is running |
| tick | input | 1 | Base tick for the counter prescaler |
| core_clk_en | output | 1 | Internal core clock enable |
| ckout_en | output | 1 | Clock output pin enable |
| stat1 | output | 1 | Status pin 1 |
| stat0 | output | 1 | Status pin 0 |
| resume | output | 1 | One-cycle strobe into interrupt exception handling |
| wdt_count | output | CNT_W | Watchdog counter value |

## Verification
The assertions check four things on every cycle. A gated clock never shows the run code and a running clock always does. Entry always advances to the standby code. The counter never moves while idle in standby, and moves by at most one per cycle while settling. A frozen counter stays frozen in run mode with the request clear. They also cover the clock-valid and manual-reset wake conditions and the single-cycle resume after a gated phase.

Only the bench scenarios can show three things. The first is the exact number of ticks to wake for each preload and prescale pairing. The second is that gated-time writes leave the preload unchanged, which shows up on the next entry. The third is the timer-line exclusion from waking.

// File: rtl/sby_pkg.sv
// Shared types and constants for the standby sequencer.
// Assumes the status code is read as {stat1, stat0}.
package sby_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTER  = 2'd1,
        ST_STBY   = 2'd2,
        ST_SETTLE = 2'd3
    } sby_state_e;

    localparam logic       ADDR_CTL      = 1'b0;
    localparam logic       ADDR_PRELOAD  = 1'b1;
    localparam int         CTL_REQ_BIT   = 0;
    localparam int         CTL_PS_LSB    = 1;

    localparam logic [1:0] CODE_RUN      = 2'b00;
    localparam logic [1:0] CODE_ENTER    = 2'b10;
    localparam logic [1:0] CODE_STBY     = 2'b01;
endpackage

// File: rtl/sby_regs.sv
// Control and preload registers of the standby sequencer.
// Writes take effect only when wr_allow is high (clock running).
// Manual reset clears the request bit but keeps prescale and preload.
module sby_regs
    import sby_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_allow,
    output logic             enter_req,
    output logic             req_q,
    output logic [PS_W-1:0]  ps_sel_q,
    output logic [CNT_W-1:0] preload_q
);
    logic wr_ctl;
    logic wr_pre;

    // Decode the two register writes, qualified by the allow signal.
    always_comb begin
        wr_ctl    = wr_en && wr_allow && man_rst_n && (wr_addr == ADDR_CTL);
        wr_pre    = wr_en && wr_allow && man_rst_n && (wr_addr == ADDR_PRELOAD);
        enter_req = wr_ctl && wr_data[CTL_REQ_BIT];
    end

    // Request bit: cleared by either reset, otherwise follows control writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !man_rst_n) begin
            req_q <= 1'b0;
        end else if (wr_ctl) begin
            req_q <= wr_data[CTL_REQ_BIT];
        end
    end

    // Prescale field and preload: cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_sel_q  <= '0;
            preload_q <= '0;
        end else begin
            if (wr_ctl) begin
                ps_sel_q <= wr_data[CTL_PS_LSB +: PS_W];
            end
            if (wr_pre) begin
                preload_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/sby_prescaler.sv
// Divides the base tick by 2^ps_sel. The phase restarts while clr is high.
// Assumes tick_in is a single-cycle pulse.
module sby_prescaler #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick_in,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick_out
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // One mask bit per prescale stage below the selected ratio.
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (32'(ps_sel) > i);
    end

    // Emit a divided tick when all low phase bits selected by the mask are set.
    always_comb begin
        tick_out = tick_in && ((phase_q & mask) == mask);
    end

    // Phase counter advances on every base tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (tick_in) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/sby_wdt_counter.sv
// Preloadable up-counter reused as the wake settling timer.
// Load has priority over increment; overflow is an all-ones increment.
module sby_wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);
    // Flag the increment that wraps the counter past all-ones.
    always_comb begin
        ovf = inc && (&cnt_q);
    end

    // Counter register: reset, preload or count.
    always_ff @(posedge clk) begin
        if (!rst_n || !man_rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sby_fsm.sv
// Phase controller: run, clock-stopping entry, standby, settling.
// Manual reset overrides every other event; resume is a registered strobe.
module sby_fsm
    import sby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       man_rst_n,
    input  logic       enter_req,
    input  logic       wake_req,
    input  logic       ovf,
    output sby_state_e state_q,
    output logic       resume_q
);
    // State and resume strobe update.
    always_ff @(posedge clk) begin
        if (!rst_n || !man_rst_n) begin
            state_q  <= ST_RUN;
            resume_q <= 1'b0;
        end else begin
            resume_q <= 1'b0;
            unique case (state_q)
                ST_RUN:    if (enter_req) state_q <= ST_ENTER;
                ST_ENTER:  state_q <= ST_STBY;
                ST_STBY:   if (wake_req) state_q <= ST_SETTLE;
                ST_SETTLE: if (ovf) begin
                    state_q  <= ST_RUN;
                    resume_q <= 1'b1;
                end
                default:   state_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/standby_seq.sv
// Top of the standby sequencer: registers, prescaler, counter and phase FSM.
// Assumes all inputs are synchronous to clk; clk_ok reports the input clock.
module standby_seq
    import sby_pkg::*;
#(
    parameter int                 CNT_W     = 8,
    parameter int                 PS_W      = 2,
    parameter int                 NUM_IRQ   = 4,
    parameter logic [NUM_IRQ-1:0] WAKE_MASK = 4'b0111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               man_rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               clk_ok,
    input  logic               tick,
    output logic               core_clk_en,
    output logic               ckout_en,
    output logic               stat1,
    output logic               stat0,
    output logic               resume,
    output logic [CNT_W-1:0]   wdt_count
);
    sby_state_e       state_q;
    logic             enter_req;
    logic             req_q;
    logic [PS_W-1:0]  ps_sel_q;
    logic [CNT_W-1:0] preload_q;
    logic             ps_tick;
    logic             cnt_inc;
    logic             cnt_ovf;
    logic             wake_req;
    logic             pre_clr;
    logic [1:0]       code;

    sby_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .man_rst_n (man_rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_allow  (state_q == ST_RUN),
        .enter_req (enter_req),
        .req_q     (req_q),
        .ps_sel_q  (ps_sel_q),
        .preload_q (preload_q)
    );

    sby_prescaler #(.PS_W(PS_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pre_clr),
        .tick_in  (tick),
        .ps_sel   (ps_sel_q),
        .tick_out (ps_tick)
    );

    sby_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .man_rst_n (man_rst_n),
        .load      (enter_req),
        .load_val  (preload_q),
        .inc       (cnt_inc),
        .cnt_q     (wdt_count),
        .ovf       (cnt_ovf)
    );

    sby_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .man_rst_n (man_rst_n),
        .enter_req (enter_req),
        .wake_req  (wake_req),
        .ovf       (cnt_ovf),
        .state_q   (state_q),
        .resume_q  (resume)
    );

    // Wake qualification, counter enable and prescaler restart.
    always_comb begin
        wake_req = (|(irq_req & WAKE_MASK)) && clk_ok;
        cnt_inc  = ps_tick && ((state_q == ST_SETTLE) || ((state_q == ST_RUN) && req_q));
        pre_clr  = (state_q == ST_ENTER) || (state_q == ST_STBY);
    end

    // Status code, core clock gate and clock output enable.
    always_comb begin
        unique case (state_q)
            ST_RUN:   code = CODE_RUN;
            ST_ENTER: code = CODE_ENTER;
            default:  code = CODE_STBY;
        endcase
        stat1       = code[1];
        stat0       = code[0];
        core_clk_en = (state_q == ST_RUN);
        ckout_en    = (state_q == ST_RUN) || !rst_n || !man_rst_n;
    end
endmodule

// File: rtl/sby_checker.sv
// Protocol checker for standby_seq, attached by bind below.
// Observes ports plus the phase state and request bit.
module sby_checker
    import sby_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             man_rst_n,
    input logic             clk_ok,
    input logic             core_clk_en,
    input logic             stat1,
    input logic             stat0,
    input logic             resume,
    input logic [CNT_W-1:0] wdt_count,
    input sby_state_e       state_q,
    input logic             req_q
);
    // R2: a gated clock never shows the run code.
    p_gated_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> ({stat1, stat0} != CODE_RUN));

    // R5: a running clock always shows the run code.
    p_run_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> ({stat1, stat0} == CODE_RUN));

    // R2: the entry phase is followed by the standby code.
    p_enter_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER && man_rst_n) |=> ({stat1, stat0} == CODE_STBY));

    // R3: counter holds while idle in standby.
    p_hold_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STBY && $past(state_q == ST_STBY)) |-> $stable(wdt_count));

    // R3: no wake while the input clock is reported stopped.
    p_clk_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STBY && !clk_ok && man_rst_n) |=> (state_q == ST_STBY));

    // R4: in settling the counter moves by at most one per cycle.
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q == ST_SETTLE)) |->
        (wdt_count == $past(wdt_count) || wdt_count == CNT_W'($past(wdt_count) + 1'b1)));

    // R5: resume only right after a gated phase, with the clock running.
    p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (core_clk_en && $past(!core_clk_en)));

    // R7: manual reset wins: clock running and no resume next cycle.
    p_mrst_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !man_rst_n |=> (core_clk_en && !resume));

    // R9: with the request bit clear in run mode, the counter is frozen.
    p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !req_q && man_rst_n &&
         $past(state_q == ST_RUN) && $past(!req_q) && $past(man_rst_n))
        |-> $stable(wdt_count));
endmodule

bind standby_seq sby_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .man_rst_n   (man_rst_n),
    .clk_ok      (clk_ok),
    .core_clk_en (core_clk_en),
    .stat1       (stat1),
    .stat0       (stat0),
    .resume      (resume),
    .wdt_count   (wdt_count),
    .state_q     (state_q),
    .req_q       (req_q)
);

// File: tb/tb_standby_seq.sv
`timescale 1ns/1ps
module tb_standby_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       man_rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] irq_req = '0;
    logic       clk_ok = 1'b1;
    logic       tick = 1'b0;
    logic       core_clk_en, ckout_en, stat1, stat0, resume;
    logic [7:0] wdt_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    standby_seq dut (
        .clk(clk), .rst_n(rst_n), .man_rst_n(man_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_req(irq_req), .clk_ok(clk_ok), .tick(tick),
        .core_clk_en(core_clk_en), .ckout_en(ckout_en),
        .stat1(stat1), .stat0(stat0), .resume(resume), .wdt_count(wdt_count)
    );

    // Wake table: {preload, prescale, base ticks to wake}.
    localparam logic [19:0] VEC [0:4] = '{
        {8'hFC, 2'd0, 10'd4},
        {8'hFF, 2'd0, 10'd1},
        {8'hF8, 2'd1, 10'd16},
        {8'hFE, 2'd2, 10'd8},
        {8'hF0, 2'd0, 10'd16}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        step(); step();
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 ckout", ckout_en, 1);
        chk("R1 code", {stat1, stat0}, 2'b00);
        chk("R1 count", wdt_count, 0);
        chk("R1 resume", resume, 0);
        rst_n = 1'b1;
        step();

        // Table walk: entry, wake and settle length for each pairing.
        for (int v = 0; v < 5; v++) begin
            logic [7:0] pl;
            logic [1:0] ps;
            int nt;
            pl = VEC[v][19:12]; ps = VEC[v][11:10]; nt = int'(VEC[v][9:0]);
            wr(1'b1, pl);
            wr(1'b0, {5'b0, ps, 1'b1});
            chk("R2 enter clk_en", core_clk_en, 0);
            chk("R2 enter code", {stat1, stat0}, 2'b10);
            chk("R2 preload", wdt_count, pl);
            step();
            chk("R2 stby code", {stat1, stat0}, 2'b01);
            chk("R7 ckout gated", ckout_en, 0);
            irq_req = 4'b0001;
            step();
            irq_req = '0;
            chk("R4 settle code", {stat1, stat0}, 2'b01);
            for (int t = 1; t < nt; t++) begin
                pulse_tick();
                chk(ps != 0 ? "R6 still gated" : "R4 still gated", core_clk_en, 0);
            end
            pulse_tick();
            chk(ps != 0 ? "R6 wake" : "R5 wake", core_clk_en, 1);
            chk("R5 run code", {stat1, stat0}, 2'b00);
            chk("R5 resume", resume, 1);
            chk("R5 wrap", wdt_count, 0);
            step();
            chk("R5 resume one cycle", resume, 0);
            wr(1'b0, 8'h00);
        end

        // R3: timer line and stopped clock do not wake; R4 once clock returns.
        wr(1'b1, 8'hFD);
        wr(1'b0, 8'h01);
        step();
        irq_req = 4'b1000;
        pulse_tick(); step();
        chk("R3 timer no wake", {stat1, stat0}, 2'b01);
        chk("R3 count hold", wdt_count, 8'hFD);
        irq_req = 4'b0010; clk_ok = 1'b0;
        step(); step();
        chk("R3 clk stopped", {stat1, stat0}, 2'b01);
        chk("R3 clk stopped gate", core_clk_en, 0);
        clk_ok = 1'b1;
        step();
        irq_req = '0;
        pulse_tick();
        chk("R4 count step", wdt_count, 8'hFE);
        chk("R4 gated", core_clk_en, 0);

        // R8: gated writes ignored.
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h00);
        chk("R8 clear ignored", {stat1, stat0}, 2'b01);
        pulse_tick(); pulse_tick();
        chk("R5 wake after R8", core_clk_en, 1);
        wr(1'b0, 8'h01);
        chk("R8 preload kept", wdt_count, 8'hFD);

        // R7: manual reset with simultaneous interrupt.
        step();
        man_rst_n = 1'b0; irq_req = 4'b0001;
        #1;
        chk("R7 ckout in reset", ckout_en, 1);
        step();
        chk("R7 clk_en", core_clk_en, 1);
        chk("R7 code", {stat1, stat0}, 2'b00);
        chk("R7 no resume", resume, 0);
        man_rst_n = 1'b1; irq_req = '0;
        step();

        // R9: counter runs after wake until the bit is cleared.
        wr(1'b1, 8'hFE);
        wr(1'b0, 8'h01);
        step();
        irq_req = 4'b0100;
        step();
        irq_req = '0;
        pulse_tick(); pulse_tick();
        chk("R9 woke", core_clk_en, 1);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R9 counting", wdt_count, 3);
        wr(1'b0, 8'h00);
        pulse_tick(); pulse_tick();
        chk("R9 halted", wdt_count, 3);
        chk("R9 running", core_clk_en, 1);

        done = 1'b1;
        finish_run();
    end
endmodule